// File: doc/BRIEF.md
# Slave-FIFO Burst Master

This controller sits on the master side of a 32-bit link to an external slave FIFO port. That port holds a fixed set of equal-sized receive buffers. Writes come from a local word source through a valid/ready handshake. Reads go to a local word sink. The controller drives the slave's write strobe, read strobe and output enable.

Flow control comes from counters rather than a continuous full flag. During a write burst, one counter tracks the words placed in the current slave buffer and a second counter tracks the words in the whole buffer set. At each buffer boundary the controller inserts a fixed number of idle cycles, so that the slave has time to move to its next buffer. When the whole set is full, the controller goes back to idle. It then waits there until the slave signals that a buffer is free again.

Reads work the same way with a separate per-buffer counter. Between local buffers the controller drops both the read strobe and the output enable, so the slave drives nothing while the local side switches buffers. Each read returns its word with a fixed latency of one cycle.

Top module: `sfifo_burst_master`

## Requirements
- R1: In idle, no strobe, no output enable and no source ready is driven. A burst starts on the clock edge after `slot_free` is seen high: `want_read`=1 selects a read burst and `want_read`=0 selects a write burst. While `slot_free` is low, the controller stays idle.
- R2: In the write-burst state, `src_ready` is 1, `slv_wr` equals `src_valid`, and `slv_wdata` equals `src_data`. A word is counted only on a cycle where `src_valid` is 1. A cycle with `src_valid` low is a stall that counts nothing.
- R3: After the last word of a slave buffer, unless it is the last word of the set, there are exactly `SWITCH_WAIT` cycles with `slv_wr` and `src_ready` both 0. Writing then resumes.
- R4: After `WORDS_PER_BUF*BUFS_PER_SET` written words, the controller returns to idle with no wait state. The count of written words starts again from zero.
- R5: In the read-burst state, `slv_oe` is 1 and `slv_rd` equals `snk_ready`. Only cycles with a strobe are counted.
- R6: After every `WORDS_PER_BUF` read strobes, unless the set is complete, there are exactly `SWITCH_WAIT` cycles with `slv_rd` and `slv_oe` both 0.
- R7: After `WORDS_PER_BUF*BUFS_PER_SET` read strobes, the controller returns to idle with `slv_oe` low.
- R8: `snk_valid` is 1 exactly in the cycle after a cycle with `slv_rd`=1. In that cycle, `snk_data` equals `slv_rdata`.
- R9: A synchronous reset, `rst`=1 at a clock edge, returns the controller to idle and clears all counters. The next burst then counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_free | input | 1 | Slave reports a buffer is available |
| want_read | input | 1 | Direction chosen at burst start: 1 read, 0 write |
| src_data | input | WORD_W | Local source word |
| src_valid | input | 1 | Local source word present |
| src_ready | output | 1 | Controller accepts source words |
| slv_wr | output | 1 | Slave write strobe |
| slv_wdata | output | WORD_W | Word driven to the slave |
| slv_rd | output | 1 | Slave read strobe |
| slv_oe | output | 1 | Slave output enable |
| slv_rdata | input | WORD_W | Word returned by the slave, one cycle after a strobe |
| snk_data | output | WORD_W | Word handed to the local sink |
| snk_valid | output | 1 | Sink word present |
| snk_ready | input | 1 | Sink can take a word one cycle later |

## Verification
Strobes, the output enable and `src_ready` are combinational on the current state and inputs, so they are due in the same cycle as the stimulus. State changes, such as a burst start, a wait entry or a return to idle, appear one clock edge after the input that causes them. `snk_valid` and the returned word trail the strobe by exactly one cycle. The bench drives inputs on the falling edge and samples one nanosecond later. It therefore always sees the outputs that the following rising edge will act on. In each expected-value row, the sink columns are shifted one row behind the strobe columns.

// File: rtl/sfifo_burst_master.sv
module sfifo_burst_master #(
  parameter int WORD_W        = 32,
  parameter int WORDS_PER_BUF = 256,
  parameter int BUFS_PER_SET  = 8,
  parameter int SWITCH_WAIT   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_free,
  input  logic              want_read,
  input  logic [WORD_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic              slv_wr,
  output logic [WORD_W-1:0] slv_wdata,
  output logic              slv_rd,
  output logic              slv_oe,
  input  logic [WORD_W-1:0] slv_rdata,
  output logic [WORD_W-1:0] snk_data,
  output logic              snk_valid,
  input  logic              snk_ready
);

  localparam int TOTAL = WORDS_PER_BUF * BUFS_PER_SET;
  localparam int BW = (WORDS_PER_BUF > 1) ? $clog2(WORDS_PER_BUF) : 1;
  localparam int TW = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam int WW = (SWITCH_WAIT > 1) ? $clog2(SWITCH_WAIT) : 1;
  localparam logic [BW-1:0] BUF_LAST  = BW'(WORDS_PER_BUF - 1);
  localparam logic [TW-1:0] SET_LAST  = TW'(TOTAL - 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(SWITCH_WAIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WR_WAIT, S_RD, S_RD_WAIT} state_t;

  state_t          state;
  logic [BW-1:0]   wb_cnt, rb_cnt;
  logic [TW-1:0]   tot_cnt;
  logic [WW-1:0]   tmr;
  logic            rd_q;

  assign src_ready = (state == S_WR);
  assign slv_wr    = (state == S_WR) && src_valid;
  assign slv_wdata = src_data;
  assign slv_oe    = (state == S_RD);
  assign slv_rd    = (state == S_RD) && snk_ready;
  assign snk_valid = rd_q;
  assign snk_data  = slv_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      wb_cnt  <= '0;
      rb_cnt  <= '0;
      tot_cnt <= '0;
      tmr     <= '0;
      rd_q    <= 1'b0;
    end else begin
      rd_q <= slv_rd;
      case (state)
        S_IDLE: begin
          wb_cnt  <= '0;
          rb_cnt  <= '0;
          tot_cnt <= '0;
          tmr     <= '0;
          if (slot_free) state <= want_read ? S_RD : S_WR;
        end
        S_WR: if (src_valid) begin
          tot_cnt <= tot_cnt + 1'b1;
          if (wb_cnt == BUF_LAST) begin
            wb_cnt <= '0;
            tmr    <= '0;
            if (tot_cnt == SET_LAST) begin
              tot_cnt <= '0;
              state   <= S_IDLE;
            end else begin
              state <= S_WR_WAIT;
            end
          end else begin
            wb_cnt <= wb_cnt + 1'b1;
          end
        end
        S_WR_WAIT: begin
          if (tmr == WAIT_LAST) state <= S_WR;
          else tmr <= tmr + 1'b1;
        end
        S_RD: if (snk_ready) begin
          tot_cnt <= tot_cnt + 1'b1;
          if (rb_cnt == BUF_LAST) begin
            rb_cnt <= '0;
            tmr    <= '0;
            if (tot_cnt == SET_LAST) begin
              tot_cnt <= '0;
              state   <= S_IDLE;
            end else begin
              state <= S_RD_WAIT;
            end
          end else begin
            rb_cnt <= rb_cnt + 1'b1;
          end
        end
        S_RD_WAIT: begin
          if (tmr == WAIT_LAST) state <= S_RD;
          else tmr <= tmr + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a write strobe only ever carries a word the source offered
  a_r2_wr_has_word: assert property (@(posedge clk) disable iff (rst)
    slv_wr |-> (src_valid && src_ready));

  // R3: the buffer-switch pause is silent on the write side
  a_r3_wait_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == S_WR_WAIT) |-> (!slv_wr && !src_ready && !slv_oe));

  // R3: a pause never outlasts the switch time
  a_r3_timer_bound: assert property (@(posedge clk) disable iff (rst)
    (state == S_WR_WAIT || state == S_RD_WAIT) |-> (tmr <= WAIT_LAST));

  // R6: no read strobe without output enable
  a_r6_rd_needs_oe: assert property (@(posedge clk) disable iff (rst)
    slv_rd |-> slv_oe);

  // R8: sink word follows a strobe by one cycle
  a_r8_valid_after_rd: assert property (@(posedge clk) disable iff (rst)
    slv_rd |=> snk_valid);

  a_r8_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    !slv_rd |=> !snk_valid);

  // R9: reset lands in idle with counters cleared
  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> (state == S_IDLE && wb_cnt == '0 && rb_cnt == '0 && tot_cnt == '0 && !snk_valid));

endmodule

// File: tb/sfifo_burst_master_tb.sv
module sfifo_burst_master_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_free = 1'b0, want_read = 1'b0, src_valid = 1'b0, snk_ready = 1'b0;
  logic [W-1:0] src_data = '0;
  logic [W-1:0] slv_rdata = '0;
  logic src_ready, slv_wr, slv_rd, slv_oe, snk_valid;
  logic [W-1:0] slv_wdata, snk_data;

  int total = 0, bad = 0;
  int rd_n = 0, exp_n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sfifo_burst_master #(.WORD_W(W), .WORDS_PER_BUF(4), .BUFS_PER_SET(2), .SWITCH_WAIT(3)) u_dut (
    .clk(clk), .rst(rst), .slot_free(slot_free), .want_read(want_read),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .slv_wr(slv_wr), .slv_wdata(slv_wdata), .slv_rd(slv_rd), .slv_oe(slv_oe),
    .slv_rdata(slv_rdata), .snk_data(snk_data), .snk_valid(snk_valid), .snk_ready(snk_ready));

  // slave model: one-cycle read latency
  always @(posedge clk) if (slv_rd) begin
    slv_rdata <= 32'hA000_0000 + W'(rd_n);
    rd_n <= rd_n + 1;
  end

  // {slot_free, want_read, src_valid, snk_ready} | {slv_wr, src_ready, slv_rd, slv_oe, snk_valid}
  // bench parameters: 4 words per buffer, 2 buffers per set, 3-cycle switch
  localparam int NV = 29;
  localparam logic [8:0] VEC [NV] = '{
    9'b0010_00000, 9'b1010_00000, 9'b0010_11000, 9'b0000_01000,
    9'b0010_11000, 9'b0010_11000, 9'b0010_11000, 9'b0010_00000,
    9'b0010_00000, 9'b0010_00000, 9'b0010_11000, 9'b0010_11000,
    9'b0010_11000, 9'b0010_11000, 9'b0010_00000, 9'b1100_00000,
    9'b0101_00110, 9'b0100_00011, 9'b0101_00110, 9'b0101_00111,
    9'b0101_00111, 9'b0101_00001, 9'b0101_00000, 9'b0101_00000,
    9'b0101_00110, 9'b0101_00111, 9'b0101_00111, 9'b0101_00111,
    9'b0101_00001};

  function automatic string row_tag(int i);
    if (i <= 1 || i == 15) return "R1";
    if (i >= 7 && i <= 9) return "R3";
    if (i == 14) return "R4";
    if (i >= 21 && i <= 23) return "R6";
    if (i == 28) return "R7";
    if (i >= 16) return "R5";
    return "R2";
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9 reset wr", W'(slv_wr), 0);
    check("R9 reset rd", W'(slv_rd | slv_oe | src_ready | snk_valid), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {slot_free, want_read, src_valid, snk_ready} = VEC[i][8:5];
      src_data = 32'h1000_0000 + W'(i);
      #1;
      check({row_tag(i), " wr"},  W'(slv_wr),    W'(VEC[i][4]));
      check({row_tag(i), " rdy"}, W'(src_ready), W'(VEC[i][3]));
      check({row_tag(i), " rd"},  W'(slv_rd),    W'(VEC[i][2]));
      check({row_tag(i), " oe"},  W'(slv_oe),    W'(VEC[i][1]));
      check("R8 valid", W'(snk_valid), W'(VEC[i][0]));
      if (VEC[i][4]) check("R2 wdata", slv_wdata, src_data);
      if (VEC[i][0]) begin
        check("R8 data", snk_data, 32'hA000_0000 + W'(exp_n));
        exp_n++;
      end
    end

    // R7: set finished, idle ignores sink ready while slot_free low
    @(negedge clk);
    {slot_free, want_read, src_valid, snk_ready} = 4'b0101;
    #1;
    check("R7 idle rd", W'(slv_rd | slv_oe), 0);
    check("R8 valid drops", W'(snk_valid), 0);

    // R9: reset mid-burst, then a fresh burst counts from zero
    @(negedge clk);
    {slot_free, want_read, src_valid, snk_ready} = 4'b1010;
    @(negedge clk);
    slot_free = 1'b0;
    #1;
    check("R2 burst began", W'(slv_wr), 1);
    @(negedge clk);
    #1;
    check("R2 second word", W'(slv_wr), 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9 idle after reset", W'(slv_wr | src_ready), 0);
    slot_free = 1'b1;
    @(negedge clk);
    slot_free = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R9 fresh count word", W'(slv_wr), 1);
      @(negedge clk);
    end
    #1;
    check("R9 wait after four words", W'(slv_wr | src_ready), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule